// File: doc/BRIEF.md
# Block Cipher Start Sequencer

This block is the register front-end of a memory-mapped block-cipher engine. The cipher rounds are not part of it. A fixed-latency stub core stands in for them: it captures one data block when a run is launched and, after a set number of cycles, publishes a transformed copy of that block. The front-end decodes a simple single-cycle register bus. It holds the input and output data words, the start-policy fields, and the interrupt mask and status. It decides the cycle in which a run begins and when the data-ready flag sets and clears.

Software selects one of three start policies:

- **Manual:** a run starts only on an explicit start strobe.
- **Auto:** a run starts once all input words have been written.
- **Word-0 trigger:** a run starts on the write to input word 0 once words 1 to 3 are loaded. This suits a DMA engine that writes the words in descending order.

In word-0 trigger mode, an optional double-buffer bit lets the next block be written while the current one is still running. That block then starts in the cycle the current run finishes. A level interrupt is raised whenever an enabled status bit is set.

Register offsets (byte addresses on `addr_i`, word aligned; unaligned or unmapped accesses are ignored):

| Offset | Register |
|---|---|
| 0x00 | control (write only, reads 0) |
| 0x04 | mode |
| 0x10 | mask set |
| 0x14 | mask clear |
| 0x18 | mask (read only) |
| 0x1C | status |
| 0x40 to 0x4C | input words 0 to 3 (write only, read 0) |
| 0x50 to 0x5C | output words 0 to 3 |

Reads return `rdata_o` combinationally in the cycle of the request.

Top module: `cipher_start_seq`

## Requirements
- R1: After reset every readable register returns 0, the control register always reads 0, and `irq_o` is low.
- R2: The mode register holds the start policy in bits 9:8 and the double-buffer enable in bit 3. With policy 0 (or the unused value 3), writing the input words never starts a run. Writing 1 to control bit 0 starts a run if none is active; a start strobe during an active run is ignored.
- R3: With policy 1, a run starts at the edge of the write that completes the set of all four input words written since the last run start. Three words alone start nothing.
- R4: With policy 2, a run starts at the edge of a write to input word 0 when words 1 to 3 have been written since the last run start. A write to word 0 without them starts nothing.
- R5: Status bit 0 (data ready) sets at the clock edge exactly LATENCY cycles after the launch edge. Each output word then equals the input word captured at launch XOR STUB_MASK.
- R6: Data ready clears when 1 is written to control bit 0 (in any policy), when 1 is written to control bit 8, or when any output word is read.
- R7: While a run is active, an input write is discarded unless policy is 2, double-buffer is set and no block is already waiting. A mode write during a run is also discarded. Each discarded write sets the sticky status bit 8.
- R8: With policy 2 and double-buffer set, a block completed during a run is held. It is launched at the edge where the current run finishes, so both results appear in order.
- R9: Writing 1s to the mask-set register sets mask bits 0, 8 and 16, and writing 1s to the mask-clear register clears them. Writes to the mask address are ignored. `irq_o` is the OR of status AND mask.
- R10: Writing 1 to control bit 8 returns all registers to their reset values and aborts any run, without setting data ready.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Bus access request, one cycle per access |
| we_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | ADDR_W | Byte address |
| wdata_i | input | DATA_W | Write data |
| rdata_o | output | DATA_W | Read data, valid in the request cycle |
| irq_o | output | 1 | Level interrupt |

## Verification
The hardest state to reach is a second block waiting behind an active run. It needs policy 2 with double-buffer set, four further input writes landing inside the LATENCY window, and the hand-over at the exact finishing edge. The bench reaches it with back-to-back directed writes right after a word-0 launch. It then reads the first result before the second run completes.

Discarded writes are judged by their effect on later results. A second manual start must reproduce the old output, not the rejected word. Randomized runs across all three policies check the exact launch-to-ready latency every time.

// File: rtl/cseq_pkg.sv
package cseq_pkg;
  typedef enum logic [1:0] {
    SMOD_MANUAL = 2'd0,
    SMOD_AUTO   = 2'd1,
    SMOD_WORD0  = 2'd2,
    SMOD_RSVD   = 2'd3
  } smod_e;

  localparam int unsigned CTRL_START_BIT = 0;
  localparam int unsigned CTRL_SRST_BIT  = 8;
  localparam int unsigned MODE_DUAL_BIT  = 3;
  localparam int unsigned MODE_SMOD_LSB  = 8;

  localparam int unsigned ST_DRDY = 0;
  localparam int unsigned ST_UACC = 8;
  localparam int unsigned ST_TAG  = 16;

  localparam int unsigned OFS_CTRL = 'h00;
  localparam int unsigned OFS_MODE = 'h04;
  localparam int unsigned OFS_MSET = 'h10;
  localparam int unsigned OFS_MCLR = 'h14;
  localparam int unsigned OFS_MASK = 'h18;
  localparam int unsigned OFS_STAT = 'h1C;
  localparam int unsigned OFS_IN   = 'h40;
  localparam int unsigned OFS_OUT  = 'h50;

  typedef struct packed {
    logic ctrl_wr;
    logic mode_wr;
    logic mode_rd;
    logic mset_wr;
    logic mclr_wr;
    logic mask_rd;
    logic stat_rd;
    logic in_wr;
    logic out_rd;
  } dec_t;
endpackage

// File: rtl/cseq_bus_decode.sv
module cseq_bus_decode
  import cseq_pkg::*;
#(
  parameter int unsigned ADDR_W    = 8,
  parameter int unsigned NUM_WORDS = 4,
  parameter int unsigned IDX_W     = 2
) (
  input  logic              req_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  output dec_t              dec_o,
  output logic [IDX_W-1:0]  idx_o
);
  localparam int unsigned WA_W = ADDR_W - 2;
  localparam logic [WA_W-1:0] WA_CTRL = WA_W'(OFS_CTRL >> 2);
  localparam logic [WA_W-1:0] WA_MODE = WA_W'(OFS_MODE >> 2);
  localparam logic [WA_W-1:0] WA_MSET = WA_W'(OFS_MSET >> 2);
  localparam logic [WA_W-1:0] WA_MCLR = WA_W'(OFS_MCLR >> 2);
  localparam logic [WA_W-1:0] WA_MASK = WA_W'(OFS_MASK >> 2);
  localparam logic [WA_W-1:0] WA_STAT = WA_W'(OFS_STAT >> 2);
  localparam logic [WA_W-1:0] WA_IN   = WA_W'(OFS_IN >> 2);
  localparam logic [WA_W-1:0] WA_OUT  = WA_W'(OFS_OUT >> 2);
  localparam logic [WA_W-1:0] WA_NUM  = WA_W'(NUM_WORDS);

  logic [WA_W-1:0] wa, in_off, out_off;
  logic            hit, wr, rd, in_hit, out_hit;

  assign wa      = addr_i[ADDR_W-1:2];
  assign hit     = req_i && (addr_i[1:0] == 2'b00);
  assign wr      = hit && we_i;
  assign rd      = hit && !we_i;
  assign in_off  = wa - WA_IN;
  assign out_off = wa - WA_OUT;
  assign in_hit  = (wa >= WA_IN) && (in_off < WA_NUM);
  assign out_hit = (wa >= WA_OUT) && (out_off < WA_NUM);

  always_comb begin
    dec_o.ctrl_wr = wr && (wa == WA_CTRL);
    dec_o.mode_wr = wr && (wa == WA_MODE);
    dec_o.mode_rd = rd && (wa == WA_MODE);
    dec_o.mset_wr = wr && (wa == WA_MSET);
    dec_o.mclr_wr = wr && (wa == WA_MCLR);
    dec_o.mask_rd = rd && (wa == WA_MASK);
    dec_o.stat_rd = rd && (wa == WA_STAT);
    dec_o.in_wr   = wr && in_hit;
    dec_o.out_rd  = rd && out_hit;
    idx_o = in_hit ? in_off[IDX_W-1:0] : out_off[IDX_W-1:0];
  end
endmodule

// File: rtl/cseq_start_ctrl.sv
module cseq_start_ctrl
  import cseq_pkg::*;
#(
  parameter int unsigned NUM_WORDS = 4,
  parameter int unsigned IDX_W     = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             srst_i,
  input  smod_e            smod_i,
  input  logic             dual_i,
  input  logic             busy_i,
  input  logic             pend_i,
  input  logic             in_wr_i,
  input  logic [IDX_W-1:0] idx_i,
  input  logic             start_i,
  output logic             accept_o,
  output logic             reject_o,
  output logic             trig_o
);
  logic [NUM_WORDS-1:0] loaded_q, loaded_nx, sel;

  assign sel       = NUM_WORDS'(1) << idx_i;
  assign accept_o  = in_wr_i && (!busy_i || (dual_i && smod_i == SMOD_WORD0 && !pend_i));
  assign reject_o  = in_wr_i && !accept_o;
  assign loaded_nx = loaded_q | (accept_o ? sel : '0);

  always_comb begin
    unique case (smod_i)
      SMOD_AUTO:  trig_o = accept_o && (&loaded_nx);
      SMOD_WORD0: trig_o = accept_o && (idx_i == '0) && (&loaded_q[NUM_WORDS-1:1]);
      default:    trig_o = start_i && !busy_i;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      loaded_q <= '0;
    else if (srst_i)  loaded_q <= '0;
    else if (trig_o)  loaded_q <= '0;
    else              loaded_q <= loaded_nx;
  end

  // a launch during a run is only legal through the double buffer
  assert_trig_busy_dual_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    trig_o && busy_i |-> dual_i && smod_i == SMOD_WORD0);
endmodule

// File: rtl/cseq_core_stub.sv
module cseq_core_stub #(
  parameter int unsigned         DATA_W    = 32,
  parameter int unsigned         NUM_WORDS = 4,
  parameter int unsigned         LATENCY   = 12,
  parameter logic [DATA_W-1:0]   STUB_MASK = 'hA5C3_0F96
) (
  input  logic                               clk_i,
  input  logic                               rst_ni,
  input  logic                               srst_i,
  input  logic                               trig_i,
  input  logic [NUM_WORDS-1:0][DATA_W-1:0]   in_words_i,
  output logic                               busy_o,
  output logic                               pend_o,
  output logic                               done_o,
  output logic [NUM_WORDS-1:0][DATA_W-1:0]   out_words_o
);
  localparam int unsigned CNT_W = (LATENCY > 1) ? $clog2(LATENCY) : 1;
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(LATENCY - 1);

  logic [NUM_WORDS-1:0][DATA_W-1:0] snap_q, out_q;
  logic [CNT_W-1:0] cnt_q;
  logic busy_q, pend_q;

  assign done_o      = busy_q && (cnt_q == CNT_LAST);
  assign busy_o      = busy_q;
  assign pend_o      = pend_q;
  assign out_words_o = out_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0; pend_q <= 1'b0; cnt_q <= '0; snap_q <= '0; out_q <= '0;
    end else if (srst_i) begin
      busy_q <= 1'b0; pend_q <= 1'b0; cnt_q <= '0; snap_q <= '0; out_q <= '0;
    end else if (done_o) begin
      out_q <= snap_q ^ {NUM_WORDS{STUB_MASK}};
      if (pend_q || trig_i) begin
        // waiting block takes over without an idle cycle
        snap_q <= in_words_i;
        cnt_q  <= '0;
        pend_q <= 1'b0;
      end else begin
        busy_q <= 1'b0;
      end
    end else if (busy_q) begin
      cnt_q <= cnt_q + 1'b1;
      if (trig_i) pend_q <= 1'b1;
    end else if (trig_i) begin
      busy_q <= 1'b1;
      cnt_q  <= '0;
      snap_q <= in_words_i;
    end
  end

  assert_cnt_range_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_q |-> cnt_q <= CNT_LAST);
  assert_no_early_end_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_q && !done_o && !srst_i |=> busy_q);
  assert_pend_needs_run_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pend_q |-> busy_q);
endmodule

// File: rtl/cseq_irq.sv
module cseq_irq
  import cseq_pkg::*;
#(
  parameter int unsigned DATA_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              srst_i,
  input  logic              mset_i,
  input  logic              mclr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              done_i,
  input  logic              drdy_clr_i,
  input  logic              uacc_set_i,
  output logic [DATA_W-1:0] mask_o,
  output logic [DATA_W-1:0] status_o,
  output logic              irq_o
);
  localparam logic [DATA_W-1:0] SRC_BITS =
    (DATA_W'(1) << ST_DRDY) | (DATA_W'(1) << ST_UACC) | (DATA_W'(1) << ST_TAG);

  logic [DATA_W-1:0] mask_q;
  logic drdy_q, uacc_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mask_q <= '0; drdy_q <= 1'b0; uacc_q <= 1'b0;
    end else if (srst_i) begin
      mask_q <= '0; drdy_q <= 1'b0; uacc_q <= 1'b0;
    end else begin
      if (mset_i)      mask_q <= mask_q | (wdata_i & SRC_BITS);
      else if (mclr_i) mask_q <= mask_q & ~(wdata_i & SRC_BITS);
      // a fresh result wins over a same-cycle clear
      if (done_i)          drdy_q <= 1'b1;
      else if (drdy_clr_i) drdy_q <= 1'b0;
      if (uacc_set_i) uacc_q <= 1'b1;
    end
  end

  always_comb begin
    status_o          = '0;
    status_o[ST_DRDY] = drdy_q;
    status_o[ST_UACC] = uacc_q;
  end

  assign mask_o = mask_q;
  assign irq_o  = |(status_o & mask_q);

  assert_uacc_sticky_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    uacc_set_i && !srst_i |=> status_o[ST_UACC]);
  assert_srst_clears_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    srst_i |=> status_o == '0 && mask_o == '0);
  assert_mask_bits_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mask_o & ~SRC_BITS) == '0);
endmodule

// File: rtl/cipher_start_seq.sv
module cipher_start_seq
  import cseq_pkg::*;
#(
  parameter int unsigned       ADDR_W    = 8,
  parameter int unsigned       DATA_W    = 32,
  parameter int unsigned       NUM_WORDS = 4,
  parameter int unsigned       LATENCY   = 12,
  parameter logic [DATA_W-1:0] STUB_MASK = 'hA5C3_0F96
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              irq_o
);
  localparam int unsigned IDX_W = (NUM_WORDS > 1) ? $clog2(NUM_WORDS) : 1;

  dec_t             dec;
  logic [IDX_W-1:0] idx;
  logic             srst, start, accept, reject, trig, busy, pend, done, mode_rej;
  smod_e            smod_q;
  logic             dual_q;
  logic [NUM_WORDS-1:0][DATA_W-1:0] in_q, in_nx, out_w;
  logic [DATA_W-1:0] mask, status;

  cseq_bus_decode #(.ADDR_W(ADDR_W), .NUM_WORDS(NUM_WORDS), .IDX_W(IDX_W)) u_dec (
    .req_i(req_i), .we_i(we_i), .addr_i(addr_i), .dec_o(dec), .idx_o(idx));

  assign srst     = dec.ctrl_wr && wdata_i[CTRL_SRST_BIT];
  assign start    = dec.ctrl_wr && wdata_i[CTRL_START_BIT] && !srst;
  assign mode_rej = dec.mode_wr && busy;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      smod_q <= SMOD_MANUAL; dual_q <= 1'b0;
    end else if (srst) begin
      smod_q <= SMOD_MANUAL; dual_q <= 1'b0;
    end else if (dec.mode_wr && !busy) begin
      smod_q <= smod_e'(wdata_i[MODE_SMOD_LSB +: 2]);
      dual_q <= wdata_i[MODE_DUAL_BIT];
    end
  end

  for (genvar g = 0; g < NUM_WORDS; g++) begin : g_in
    assign in_nx[g] = (accept && idx == IDX_W'(g)) ? wdata_i : in_q[g];
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)   in_q[g] <= '0;
      else if (srst) in_q[g] <= '0;
      else           in_q[g] <= in_nx[g];
    end
  end

  cseq_start_ctrl #(.NUM_WORDS(NUM_WORDS), .IDX_W(IDX_W)) u_start (
    .clk_i(clk_i), .rst_ni(rst_ni), .srst_i(srst), .smod_i(smod_q), .dual_i(dual_q),
    .busy_i(busy), .pend_i(pend), .in_wr_i(dec.in_wr), .idx_i(idx), .start_i(start),
    .accept_o(accept), .reject_o(reject), .trig_o(trig));

  cseq_core_stub #(.DATA_W(DATA_W), .NUM_WORDS(NUM_WORDS), .LATENCY(LATENCY),
                   .STUB_MASK(STUB_MASK)) u_core (
    .clk_i(clk_i), .rst_ni(rst_ni), .srst_i(srst), .trig_i(trig), .in_words_i(in_nx),
    .busy_o(busy), .pend_o(pend), .done_o(done), .out_words_o(out_w));

  cseq_irq #(.DATA_W(DATA_W)) u_irq (
    .clk_i(clk_i), .rst_ni(rst_ni), .srst_i(srst), .mset_i(dec.mset_wr),
    .mclr_i(dec.mclr_wr), .wdata_i(wdata_i), .done_i(done),
    .drdy_clr_i(start || dec.out_rd), .uacc_set_i(reject || mode_rej),
    .mask_o(mask), .status_o(status), .irq_o(irq_o));

  always_comb begin
    rdata_o = '0;
    if (dec.mode_rd) begin
      rdata_o[MODE_SMOD_LSB +: 2] = smod_q;
      rdata_o[MODE_DUAL_BIT]      = dual_q;
    end
    if (dec.mask_rd) rdata_o = mask;
    if (dec.stat_rd) rdata_o = status;
    if (dec.out_rd)  rdata_o = out_w[idx];
  end

  assert_mode_hold_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mode_rej |=> $stable(smod_q) && $stable(dual_q));
  assert_reject_keeps_word_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reject && !srst |=> $stable(in_q));
  assert_srst_idle_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    srst |=> !busy && status[ST_DRDY] == 1'b0);
endmodule

// File: tb/cipher_start_seq_tb.sv
module cipher_start_seq_tb;
  localparam int unsigned LAT = 12;
  localparam logic [31:0] MSK = 32'h3C5A_F00F;
  localparam logic [7:0] A_CTRL = 8'h00, A_MODE = 8'h04, A_MSET = 8'h10, A_MCLR = 8'h14,
                         A_MASK = 8'h18, A_STAT = 8'h1C, A_IN = 8'h40, A_OUT = 8'h50;

  logic clk = 1'b0, rst_n = 1'b0, req = 1'b0, we = 1'b0, irq;
  logic [7:0] addr = '0;
  logic [31:0] wdata = '0, rdata;
  int checks = 0, errors = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  cipher_start_seq #(.ADDR_W(8), .DATA_W(32), .NUM_WORDS(4), .LATENCY(LAT), .STUB_MASK(MSK))
  u_dut (.clk_i(clk), .rst_ni(rst_n), .req_i(req), .we_i(we), .addr_i(addr),
         .wdata_i(wdata), .rdata_o(rdata), .irq_o(irq));

  function automatic logic [31:0] expect_out(input logic [31:0] w);
    return w ^ MSK;
  endfunction

  task automatic chk(input string r, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", r, got, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk); req = 1'b1; we = 1'b1; addr = a; wdata = d;
    @(posedge clk); #1 req = 1'b0; we = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d, output logic i);
    @(negedge clk); req = 1'b1; we = 1'b0; addr = a;
    #1 d = rdata; i = irq;
    @(posedge clk); #1 req = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic chk_reg(input string r, input logic [7:0] a, input logic [31:0] exp);
    logic [31:0] d; logic i;
    rd(a, d, i);
    chk(r, d, exp);
  endtask

  task automatic chk_outs(input string r, input logic [31:0] blk [4]);
    for (int k = 0; k < 4; k++) chk_reg(r, A_OUT + 8'(4 * k), expect_out(blk[k]));
  endtask

  task automatic soft_reset();
    wr(A_CTRL, 32'h100);
  endtask

  initial begin
    logic [31:0] a [4], b [4], d;
    logic i;
    int unsigned seed;
    seed = 32'd1234;
    void'($urandom(seed));
    #23 rst_n = 1'b1;
    idle(2);

    // R1 reset state
    chk_reg("R1 ctrl", A_CTRL, 0);
    chk_reg("R1 mode", A_MODE, 0);
    chk_reg("R1 mask", A_MASK, 0);
    chk_reg("R1 status", A_STAT, 0);
    rd(A_OUT, d, i);
    chk("R1 out0", d, 0);
    chk("R1 irq", {31'b0, i}, 0);

    // R2 manual: words alone never start, START does
    for (int k = 0; k < 4; k++) a[k] = $urandom;
    for (int k = 0; k < 4; k++) wr(A_IN + 8'(4 * k), a[k]);
    idle(2 * LAT);
    chk_reg("R2 no start on writes", A_STAT, 0);
    wr(A_CTRL, 32'h1);
    idle(LAT - 1);
    chk_reg("R5 not ready before latency", A_STAT, 0);
    chk_reg("R5 ready at latency", A_STAT, 32'h1);
    chk_reg("R1 ctrl reads zero", A_CTRL, 0);
    chk_outs("R5 manual result", a);
    chk_reg("R6 out read clears ready", A_STAT, 0);

    // R7 discarded input write during a non-double-buffered run
    wr(A_CTRL, 32'h1);
    idle(2);
    wr(A_IN + 8'h8, ~a[2]);
    wr(A_MODE, 32'h100);
    chk_reg("R7 mode write discarded", A_MODE, 0);
    chk_reg("R7 access flag", A_STAT, 32'h100);
    idle(LAT);
    wr(A_CTRL, 32'h1);
    idle(LAT + 2);
    chk_outs("R7 input word kept", a);

    // R6 START clears data ready (auto mode, so no run)
    soft_reset();
    wr(A_MODE, 32'h100);
    chk_reg("R2 mode field", A_MODE, 32'h100);
    for (int k = 0; k < 3; k++) wr(A_IN + 8'(4 * k), a[k]);
    idle(2 * LAT);
    chk_reg("R3 three words no start", A_STAT, 0);
    wr(A_IN + 8'hC, a[3]);
    idle(LAT + 1);
    chk_reg("R3 fourth word starts", A_STAT, 32'h1);
    wr(A_CTRL, 32'h1);
    chk_reg("R6 START clears ready", A_STAT, 0);
    chk_outs("R3 result", a);

    // R4 word-0 trigger needs words 1..3
    soft_reset();
    wr(A_MODE, 32'h200);
    wr(A_IN, a[0]);
    idle(2 * LAT);
    chk_reg("R4 lone word0 no start", A_STAT, 0);

    // R9 mask handling and irq
    wr(A_MSET, 32'hFFFF_FFFF);
    chk_reg("R9 mask set", A_MASK, 32'h0001_0101);
    wr(A_MCLR, 32'h100);
    chk_reg("R9 mask clear", A_MASK, 32'h0001_0001);
    wr(A_MASK, 32'h0);
    chk_reg("R9 mask read only", A_MASK, 32'h0001_0001);
    for (int k = 1; k < 4; k++) wr(A_IN + 8'(4 * k), a[k]);
    rd(A_STAT, d, i);
    chk("R9 irq low idle", {31'b0, i}, 0);
    wr(A_IN, a[0]);
    idle(LAT + 1);
    rd(A_STAT, d, i);
    chk("R4 word0 launch", d, 32'h1);
    chk("R9 irq high", {31'b0, i}, 1);
    wr(A_MCLR, 32'h1);
    rd(A_STAT, d, i);
    chk("R9 irq masked", {31'b0, i}, 0);

    // R8 double buffer: second block queued during first run
    soft_reset();
    wr(A_MODE, 32'h208);
    for (int k = 0; k < 4; k++) begin a[k] = $urandom; b[k] = $urandom; end
    for (int k = 3; k >= 0; k--) wr(A_IN + 8'(4 * k), a[k]);
    for (int k = 3; k >= 0; k--) wr(A_IN + 8'(4 * k), b[k]);
    chk_reg("R8 accepted writes not flagged", A_STAT, 0);
    idle(LAT);
    chk_outs("R8 first block", a);
    idle(2 * LAT);
    chk_reg("R8 second ready", A_STAT, 32'h1);
    chk_outs("R8 second block", b);

    // R10 soft reset aborts a run
    wr(A_MODE, 32'h0);
    wr(A_MSET, 32'h1);
    wr(A_CTRL, 32'h1);
    idle(3);
    soft_reset();
    idle(2 * LAT);
    rd(A_STAT, d, i);
    chk("R10 no ready after abort", d, 0);
    chk("R10 irq low", {31'b0, i}, 0);
    chk_reg("R10 mask reset", A_MASK, 0);
    chk_reg("R10 out reset", A_OUT + 8'h4, 0);
    chk_reg("R10 mode reset", A_MODE, 0);

    // randomized runs, all policies, exact latency
    for (int it = 0; it < 24; it++) begin
      int unsigned pol, rot;
      pol = $urandom_range(2, 0);
      rot = $urandom_range(3, 0);
      soft_reset();
      wr(A_MODE, 32'(pol) << 8);
      for (int k = 0; k < 4; k++) a[k] = $urandom;
      if (pol == 0) begin
        for (int k = 0; k < 4; k++) wr(A_IN + 8'(4 * ((k + rot) % 4)), a[(k + rot) % 4]);
        wr(A_CTRL, 32'h1);
      end else if (pol == 1) begin
        for (int k = 0; k < 4; k++) wr(A_IN + 8'(4 * ((k + rot) % 4)), a[(k + rot) % 4]);
      end else begin
        for (int k = 3; k >= 0; k--) wr(A_IN + 8'(4 * k), a[k]);
      end
      idle(LAT - 1);
      chk_reg("R5 random early", A_STAT, 0);
      chk_reg("R5 random ready", A_STAT, 32'h1);
      chk_outs("R5 random result", a);
      chk_reg("R6 random clear", A_STAT, 0);
    end

    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      errors++;
      checks++;
      $display("FAIL watchdog: got hang expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule